// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether a guest port I/O access has to leave the guest. A request carries a 16-bit port number, an access-parameter word, the current instruction pointer and the length of the instruction. When the I/O intercept is enabled, the block fetches one 16-bit little-endian word from an external permission bitmap. The word sits at the bitmap base plus the port number divided by eight.

From the access-size field it builds a run of ones, shifted up by the port's position inside its byte. If any bitmap bit under that run is set, the access exits. Because the run can start late in a byte, one check can cover bits in two adjacent bitmap bytes. On an exit the block reports two values:
- a packed first exit word, holding the parameter word and the port number;
- the address of the next instruction.

Only one check is in flight at a time. Each accepted request ends with exactly one completion pulse, whether or not it exits. When the intercept is disabled, the block completes without touching memory.

Top module: `iopm_check`

## Requirements
- R1: After reset, busy_o, done_o, exit_o and mem_req_o are all 0.
- R2: When io_icpt_en_i is 0 at acceptance, the block makes no memory request, pulses done_o in the cycle after acceptance, and exit_o stays 0.
- R3: When enabled, mem_req_o is held high with mem_addr_o = bmp_base_i + (port_i >> 3) until mem_rvalid_i is seen. mem_rdata_i[7:0] is the byte at that address and mem_rdata_i[15:8] is the byte at the next address.
- R4: The access size n is param_i[6:4]. The covered run is n consecutive bits, so n = 0 never exits.
- R5: An exit occurs when mem_rdata_i & (((1 << n) - 1) << port_i[2:0]) is nonzero. This lets a check reach into the second fetched byte.
- R6: On an exit, exit_info1_o = zero-extended param_i OR (port_i << 16).
- R7: On an exit, exit_info2_o = ip_i + ilen_i.
- R8: Each accepted request gives exactly one done_o pulse of one cycle. exit_o is high only together with done_o, and both info outputs read 0 whenever exit_o is 0.
- R9: start_i is ignored while busy_o is 1; the check in flight keeps its own port, parameter and pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a check; accepted when idle |
| io_icpt_en_i | input | 1 | I/O intercept enable from the intercept vector |
| port_i | input | 16 | Accessed I/O port number |
| param_i | input | 32 | Access parameter word, size in bits 6:4 |
| ip_i | input | 64 | Current instruction pointer |
| ilen_i | input | 4 | Instruction length in bytes |
| bmp_base_i | input | 64 | Permission bitmap base address, stable during a check |
| mem_req_o | output | 1 | Bitmap read request |
| mem_addr_o | output | 64 | Bitmap byte address |
| mem_rdata_i | input | 16 | Bitmap word, lower address in low byte |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Check in flight |
| done_o | output | 1 | One-cycle completion pulse |
| exit_o | output | 1 | Access must exit, valid with done_o |
| exit_info1_o | output | 64 | Packed parameter and port on exit, else 0 |
| exit_info2_o | output | 64 | Next instruction pointer on exit, else 0 |

## Verification
Ports are swept across every bit offset within a byte, and the access sizes run from 0 to 7. The bitmap pattern mixes empty bytes with dense ones, so set bits that fall just outside the covered run are told apart from those inside it. Directed cases cover the following:
- a run that starts at bit 6 and only hits a bit in the second byte, which separates a 16-bit fetch from a byte fetch;
- port 0xFFFF, which exercises the top of the address range;
- size 0 over an all-ones word;
- a parameter word whose high half overlaps the port field in the first exit word.

Disabled-intercept requests and back-to-back starts while busy check that no read is issued and that the first request's values survive.

// File: rtl/iopm_pkg.sv
package iopm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_DECIDE = 2'd2
  } chk_state_e;

  localparam int unsigned BYTE_SH = 3;  // port bits selecting a bit within a bitmap byte
endpackage

// File: rtl/iopm_mask_gen.sv
module iopm_mask_gen
  import iopm_pkg::*;
#(
  parameter int unsigned PORT_W = 16,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned ADDR_W = 64
) (
  input  logic [PORT_W-1:0] port_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] window_o
);
  localparam int unsigned CMP_W = $clog2(WORD_W) + 2;

  logic [CMP_W-1:0] lo;
  logic [CMP_W-1:0] hi;

  assign lo     = CMP_W'(port_i[BYTE_SH-1:0]);
  assign hi     = lo + CMP_W'(size_i);
  assign addr_o = base_i + ADDR_W'(port_i >> BYTE_SH);

  // per-bit range compare: bit b covered when lo <= b < lo + size
  for (genvar b = 0; b < WORD_W; b++) begin : g_win
    localparam logic [CMP_W-1:0] IDX = CMP_W'(b);
    assign window_o[b] = (IDX >= lo) && (IDX < hi);
  end
endmodule

// File: rtl/iopm_req_ctrl.sv
module iopm_req_ctrl
  import iopm_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rvalid_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              accept_o,
  output logic              load_o,
  output logic              done_o,
  output logic              busy_o
);
  chk_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;

  assign accept_o   = (state_q == ST_IDLE) && start_i;
  assign load_o     = (state_q == ST_READ) && rvalid_i;
  assign mem_req_o  = (state_q == ST_READ);
  assign mem_addr_o = addr_q;
  assign done_o     = (state_q == ST_DECIDE);
  assign busy_o     = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = enable_i ? ST_READ : ST_DECIDE;
      ST_READ:   if (rvalid_i) state_d = ST_DECIDE;
      ST_DECIDE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept_o && enable_i) addr_q <= addr_i;
    end
  end

  p_skip_no_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !enable_i) |=> (!mem_req_o && done_o));

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> busy_o);
endmodule

// File: rtl/iopm_exit_pack.sv
module iopm_exit_pack #(
  parameter int unsigned PORT_W  = 16,
  parameter int unsigned PARAM_W = 32,
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned IP_W    = 64,
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned INFO_W  = 64,
  parameter int unsigned PORT_SH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               enable_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic [PARAM_W-1:0] param_i,
  input  logic [IP_W-1:0]    ip_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [WORD_W-1:0]  window_i,
  input  logic               load_i,
  input  logic [WORD_W-1:0]  rdata_i,
  input  logic               done_i,
  output logic               exit_o,
  output logic [INFO_W-1:0]  info1_o,
  output logic [IP_W-1:0]    info2_o
);
  logic [WORD_W-1:0] window_q;
  logic [WORD_W-1:0] word_q;
  logic [INFO_W-1:0] info1_q;
  logic [IP_W-1:0]   info2_q;
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      window_q <= '0;
      word_q   <= '0;
      info1_q  <= '0;
      info2_q  <= '0;
    end else begin
      if (accept_i) begin
        window_q <= enable_i ? window_i : '0;
        word_q   <= '0;
        info1_q  <= INFO_W'(param_i) | (INFO_W'(port_i) << PORT_SH);
        info2_q  <= ip_i + IP_W'(len_i);
      end
      if (load_i) word_q <= rdata_i;
    end
  end

  assign hit     = |(word_q & window_q);
  assign exit_o  = done_i && hit;
  assign info1_o = exit_o ? info1_q : '0;
  assign info2_o = exit_o ? info2_q : '0;

  p_hold_info_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($stable(info1_q) && $stable(info2_q) && $stable(window_q)));

  p_word_only_on_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !load_i) |=> $stable(word_q));
endmodule

// File: rtl/iopm_check.sv
module iopm_check
  import iopm_pkg::*;
#(
  parameter int unsigned PORT_W   = 16,
  parameter int unsigned PARAM_W  = 32,
  parameter int unsigned IP_W     = 64,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SIZE_LSB = 4,
  parameter int unsigned SIZE_W   = 3,
  parameter int unsigned INFO_W   = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               io_icpt_en_i,
  input  logic [PORT_W-1:0]  port_i,
  input  logic [PARAM_W-1:0] param_i,
  input  logic [IP_W-1:0]    ip_i,
  input  logic [LEN_W-1:0]   ilen_i,
  input  logic [ADDR_W-1:0]  bmp_base_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  input  logic               mem_rvalid_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               exit_o,
  output logic [INFO_W-1:0]  exit_info1_o,
  output logic [IP_W-1:0]    exit_info2_o
);
  localparam int unsigned PORT_SH = INFO_W / 4;

  logic [SIZE_W-1:0] size;
  logic [ADDR_W-1:0] fetch_addr;
  logic [WORD_W-1:0] window;
  logic              accept;
  logic              load;

  assign size = param_i[SIZE_LSB +: SIZE_W];

  iopm_mask_gen #(
    .PORT_W(PORT_W), .WORD_W(WORD_W), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W)
  ) u_mask (
    .port_i  (port_i),
    .size_i  (size),
    .base_i  (bmp_base_i),
    .addr_o  (fetch_addr),
    .window_o(window)
  );

  iopm_req_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .enable_i  (io_icpt_en_i),
    .addr_i    (fetch_addr),
    .rvalid_i  (mem_rvalid_i),
    .mem_req_o (mem_req_o),
    .mem_addr_o(mem_addr_o),
    .accept_o  (accept),
    .load_o    (load),
    .done_o    (done_o),
    .busy_o    (busy_o)
  );

  iopm_exit_pack #(
    .PORT_W(PORT_W), .PARAM_W(PARAM_W), .WORD_W(WORD_W), .IP_W(IP_W),
    .LEN_W(LEN_W), .INFO_W(INFO_W), .PORT_SH(PORT_SH)
  ) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .enable_i(io_icpt_en_i),
    .port_i  (port_i),
    .param_i (param_i),
    .ip_i    (ip_i),
    .len_i   (ilen_i),
    .window_i(window),
    .load_i  (load),
    .rdata_i (mem_rdata_i),
    .done_i  (done_o),
    .exit_o  (exit_o),
    .info1_o (exit_info1_o),
    .info2_o (exit_info2_o)
  );

  p_exit_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |-> (done_o && busy_o));

  p_size0_no_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (size == '0)) |=> ##1 !exit_o);
endmodule

// File: tb/sim_iopm_check.sv
module sim_iopm_check;
  localparam logic [63:0] BASE = 64'h0000_0012_3450_0000;
  localparam int NV = 12;
  localparam logic [15:0] V_PORT [NV] = '{
    16'h0000, 16'h0007, 16'h0060, 16'h03F8, 16'h1234, 16'h2F0D,
    16'h0080, 16'hFFFF, 16'h0C01, 16'h5555, 16'hAAAA, 16'h7FFB};
  localparam logic [31:0] V_PARAM [NV] = '{
    32'h0000_0010, 32'h0000_0021, 32'h0000_0049, 32'h0000_0010,
    32'h0000_002C, 32'h0000_0040, 32'h0000_0000, 32'h0000_0010,
    32'h0000_0070, 32'h0001_0048, 32'h0000_0020, 32'h0000_0040};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        io_icpt_en_i = 1'b0;
  logic [15:0] port_i = '0;
  logic [31:0] param_i = '0;
  logic [63:0] ip_i = '0;
  logic [3:0]  ilen_i = '0;
  logic [63:0] bmp_base_i = BASE;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic [15:0] mem_rdata_i;
  logic        mem_rvalid_i;
  logic        busy_o, done_o, exit_o;
  logic [63:0] exit_info1_o, exit_info2_o;

  logic [7:0]  bmp [1024];
  int          n_run = 0;
  int          n_fail = 0;
  int          cyc = 0;

  // result of the last check
  int          r_reqs;
  logic [63:0] r_addr;
  logic        r_done, r_exit;
  logic [63:0] r_i1, r_i2;

  always #5 clk_i = ~clk_i;

  iopm_check u0 (.*);

  // bitmap memory: one-cycle response
  logic [9:0] m_idx;
  assign m_idx = 10'(mem_addr_o - BASE);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_rvalid_i <= 1'b0;
      mem_rdata_i  <= '0;
    end else begin
      mem_rvalid_i <= mem_req_o && !mem_rvalid_i;
      mem_rdata_i  <= {bmp[m_idx + 10'd1], bmp[m_idx]};
    end
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [15:0] p, input logic [31:0] prm);
    logic [9:0]  idx;
    logic [15:0] w;
    logic [31:0] m;
    idx = 10'(p >> 3);
    w   = {bmp[idx + 10'd1], bmp[idx]};
    m   = ((32'd1 << prm[6:4]) - 32'd1) << p[2:0];
    return |(w & m[15:0]);
  endfunction

  task automatic run_one(input logic [15:0] p, input logic [31:0] prm,
                         input logic [63:0] ip, input logic [3:0] len, input logic en);
    @(negedge clk_i);
    port_i = p; param_i = prm; ip_i = ip; ilen_i = len;
    io_icpt_en_i = en; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    r_reqs = 0; r_addr = '0; r_done = 1'b0; r_exit = 1'b0; r_i1 = '0; r_i2 = '0;
    for (int k = 0; k < 40; k++) begin
      if (mem_req_o) begin
        r_reqs++;
        r_addr = mem_addr_o;
      end
      if (done_o) begin
        r_done = 1'b1; r_exit = exit_o; r_i1 = exit_info1_o; r_i2 = exit_info2_o;
        break;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic check_result(input logic [15:0] p, input logic [31:0] prm,
                              input logic [63:0] ip, input logic [3:0] len);
    logic        h;
    logic [63:0] e1, e2;
    h  = exp_hit(p, prm);
    e1 = h ? (64'(prm) | (64'(p) << 16)) : 64'd0;
    e2 = h ? (ip + 64'(len)) : 64'd0;
    chk(r_done, "R8", "done pulse", 64'(r_done), 64'd1);
    chk(r_reqs >= 1, "R3", "request seen", 64'(r_reqs), 64'd1);
    chk(r_addr == BASE + 64'(p >> 3), "R3", "fetch address", r_addr, BASE + 64'(p >> 3));
    chk(r_exit == h, "R5", "exit decision", 64'(r_exit), 64'(h));
    chk(r_i1 == e1, "R6", "exit info1", r_i1, e1);
    chk(r_i2 == e2, "R7", "exit info2", r_i2, e2);
  endtask

  initial begin
    logic [63:0] ipv;
    for (int i = 0; i < 1024; i++)
      bmp[i] = (i % 3 == 0) ? 8'h00 : 8'((i * 29) ^ 90);

    // R1: reset state
    #1;
    chk(!busy_o && !done_o && !exit_o && !mem_req_o, "R1", "reset outputs",
        {60'd0, busy_o, done_o, exit_o, mem_req_o}, 64'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !exit_o && !mem_req_o, "R1", "idle after reset",
        {60'd0, busy_o, done_o, exit_o, mem_req_o}, 64'd0);

    // vector table: R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      ipv = 64'h0000_7FFF_0000_1000 + 64'(i * 273);
      run_one(V_PORT[i], V_PARAM[i], ipv, 4'(i + 1), 1'b1);
      check_result(V_PORT[i], V_PARAM[i], ipv, 4'(i + 1));
    end

    // R5: run spans into the second fetched byte
    bmp[100] = 8'h00; bmp[101] = 8'h01;
    run_one(16'd806, 32'h40, 64'h1000, 4'd2, 1'b1);
    chk(r_exit == 1'b1, "R5", "cross-byte hit", 64'(r_exit), 64'd1);
    chk(r_i1 == 64'h0326_0040, "R6", "cross-byte info1", r_i1, 64'h0326_0040);
    chk(r_i2 == 64'h1002, "R7", "cross-byte info2", r_i2, 64'h1002);
    run_one(16'd804, 32'h20, 64'h1000, 4'd2, 1'b1);
    chk(r_exit == 1'b0, "R5", "same word no hit", 64'(r_exit), 64'd0);
    chk(r_i1 == 64'd0 && r_i2 == 64'd0, "R8", "info zero without exit", r_i1 | r_i2, 64'd0);

    // R4: size 0 over all-ones word never exits
    bmp[200] = 8'hFF; bmp[201] = 8'hFF;
    run_one(16'd1603, 32'h0000_0F8F, 64'h2000, 4'd3, 1'b1);
    chk(r_exit == 1'b0, "R4", "size zero", 64'(r_exit), 64'd0);
    run_one(16'd1603, 32'h0000_0070, 64'h2000, 4'd3, 1'b1);
    chk(r_exit == 1'b1, "R4", "size seven", 64'(r_exit), 64'd1);

    // R2: intercept disabled, all-ones bitmap region
    run_one(16'd1603, 32'h0000_0070, 64'h2000, 4'd3, 1'b0);
    chk(r_reqs == 0, "R2", "no memory request", 64'(r_reqs), 64'd0);
    chk(r_done == 1'b1, "R2", "done still pulses", 64'(r_done), 64'd1);
    chk(r_exit == 1'b0, "R2", "no exit when disabled", 64'(r_exit), 64'd0);

    // R8: done lasts one cycle
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R8", "done single cycle", {62'd0, done_o, busy_o}, 64'd0);

    // R9: second start while busy is ignored
    @(negedge clk_i);
    port_i = 16'd1600; param_i = 32'h10; ip_i = 64'h3000; ilen_i = 4'd1;
    io_icpt_en_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    port_i = 16'd806; param_i = 32'h0000_0070; ip_i = 64'h9999; ilen_i = 4'd7;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 20 && !done_o; k++) @(negedge clk_i);
    // bit 0 of byte 200 is set: first request hits
    chk(exit_o == 1'b1, "R9", "first request kept", 64'(exit_o), 64'd1);
    chk(exit_info1_o == 64'h0640_0010, "R9", "first info1 kept", exit_info1_o, 64'h0640_0010);
    chk(exit_info2_o == 64'h3001, "R9", "first info2 kept", exit_info2_o, 64'h3001);
    @(negedge clk_i);
    chk(!busy_o, "R9", "no second check started", 64'(busy_o), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule